// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a pipelined command interface and a built-in burst address counter. It accepts one command on every clock edge where its clock enable is asserted. A command can load a fresh address for a read or a write, step the current burst to its next word, or stop. Data for every access moves two enabled clock edges after its command. Reads and writes use the same two-edge offset, so any mix of them can run back to back on one logical data bus without idle cycles.

The word width, the byte-lane width and the depth are parameters. The default is a 36-bit word split into four 9-bit lanes, and each lane has its own active-low write enable. Because the design targets fabric, the shared bus appears as an input word, an output word and an output-enable. The tristate pad that joins them sits outside the block.

Top module: `zbt_sram`

## Requirements
- R1: The composite chip select is true only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. A load command (`adv_burst`=0) taken while the select is false starts no access and ends any burst in progress.
- R2: A command is taken only on a rising edge where `clk_en_n`=0. On an edge where `clk_en_n`=1 every input except `rst` and `out_en_n` is ignored, and all pipeline state holds: the burst address, the pending data phases and the read output word.
- R3: A load with the select true captures `addr`. `rd_not_wr`=1 starts a read and `rd_not_wr`=0 starts a write.
- R4: For a read taken at enabled edge E, `dq_out` carries the addressed word from enabled edge E+1 up to and including enabled edge E+2. `dq_oe` is 1 during that cycle only while `out_en_n`=0, and is 0 otherwise.
- R5: For a write taken at enabled edge E, `dq_in` is captured at enabled edge E+2. Lane b is bits [9b+8:9b] in the default configuration. It is written only if `lane_wr_n[b]`=0 was sampled together with that write's command. Unselected lanes keep their old contents.
- R6: A command with `adv_burst`=1 that follows an access ignores `addr` and `rd_not_wr`. It performs the next access in the same direction. The two least significant address bits step by +1 modulo 4, and the upper bits do not change, so the fifth access of a burst returns to the first address.
- R7: After a stop, commands with `adv_burst`=1 are no-ops until the next load with the select true. In the data phase of a stop or a no-op, `dq_oe` stays 0 and `dq_in` is not stored.
- R8: Reads and writes may be issued on consecutive enabled edges in any order with no idle cycle between them. Each keeps its own two-edge data phase.
- R9: A read of the same address issued on the enabled edge right after a write returns that write's new lanes, merged with the old contents of the unwritten lanes.
- R10: `rst` is synchronous and active high. After it, no access is pending, `dq_oe` is 0, and commands with `adv_burst`=1 are no-ops until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| cs_a_n | input | 1 | Chip select term, active low |
| cs_b_n | input | 1 | Chip select term, active low |
| cs_c | input | 1 | Chip select term, active high |
| adv_burst | input | 1 | 1 = continue burst, 0 = load a new address |
| rd_not_wr | input | 1 | Direction for a load: 1 read, 0 write |
| addr | input | ADDR_W | Word address for a load |
| lane_wr_n | input | DATA_W/LANE_W | Active-low per-lane write enables, sampled with the command |
| out_en_n | input | 1 | Active-low asynchronous output enable |
| dq_in | input | DATA_W | Bus value seen at the pad (write data) |
| dq_out | output | DATA_W | Read word presented to the pad |
| dq_oe | output | 1 | Pad drive enable for `dq_out` |

## Verification
A wrong burst counter shows up at the ports two enabled edges after the faulty step: the data word belongs to a neighbouring address, or a wrapped burst returns to the wrong place. A pipeline that advances during a freeze shows up at once, because the read word or the drive enable changes while `clk_en_n` is high. A missing bypass or a wrong lane mask appears as a stale or mixed word on the first read that touches the address. An access that leaks out of a stop or a no-op appears either as a drive enable two edges later or as corrupted contents at the next read-back. The sweeps write every word, every lane mask, every burst start offset and every select combination, and then read them back.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  // Command class decoded from the control pins on an enabled edge
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,  // burst request with no burst open: no-op
    CMD_LOAD  = 2'd1,  // new address, direction from rd_not_wr
    CMD_BURST = 2'd2,  // next word of the open burst
    CMD_STOP  = 2'd3   // load with select false: close the burst
  } cmd_e;

endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int WRAP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              cs_c,
  input  logic              adv_burst,
  input  logic              rd_not_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              acc_vld,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_lane_n
);

  logic              sel_ok;
  logic              active_q;
  logic              acc_vld_q;
  logic              acc_wr_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic [LANES-1:0]  acc_lane_n_q;
  logic [ADDR_W-1:0] nxt_addr;
  cmd_e              kind;

  assign sel_ok = !cs_a_n && !cs_b_n && cs_c;

  always_comb begin
    if (!adv_burst) kind = sel_ok ? CMD_LOAD : CMD_STOP;
    else            kind = active_q ? CMD_BURST : CMD_IDLE;
  end

  // Linear wrap inside the low WRAP_W bits
  assign nxt_addr = {acc_addr_q[ADDR_W-1:WRAP_W],
                     acc_addr_q[WRAP_W-1:0] + WRAP_W'(1)};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q     <= 1'b0;
      acc_vld_q    <= 1'b0;
      acc_wr_q     <= 1'b0;
      acc_addr_q   <= '0;
      acc_lane_n_q <= '1;
    end else if (!clk_en_n) begin
      acc_lane_n_q <= lane_wr_n;
      case (kind)
        CMD_LOAD: begin
          active_q   <= 1'b1;
          acc_vld_q  <= 1'b1;
          acc_wr_q   <= !rd_not_wr;
          acc_addr_q <= addr;
        end
        CMD_BURST: begin
          acc_vld_q  <= 1'b1;
          acc_addr_q <= nxt_addr;
        end
        CMD_STOP: begin
          active_q  <= 1'b0;
          acc_vld_q <= 1'b0;
        end
        default: acc_vld_q <= 1'b0;
      endcase
    end
  end

  assign acc_vld    = acc_vld_q;
  assign acc_wr     = acc_wr_q;
  assign acc_addr   = acc_addr_q;
  assign acc_lane_n = acc_lane_n_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_burst && sel_ok) |=>
      (acc_vld_q && acc_addr_q == $past(addr) && acc_wr_q == !$past(rd_not_wr))); // R3

  AST_UNSELECTED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_burst && (cs_a_n || cs_b_n || !cs_c)) |=> !acc_vld_q); // R1

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && kind == CMD_BURST) |=>
      (acc_addr_q[ADDR_W-1:WRAP_W] == $past(acc_addr_q[ADDR_W-1:WRAP_W]) &&
       acc_addr_q[WRAP_W-1:0] == $past(acc_addr_q[WRAP_W-1:0]) + WRAP_W'(1))); // R6

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(acc_addr_q) && $stable(acc_vld_q) && $stable(active_q))); // R2

endmodule

// File: rtl/zbt_data_pipe.sv
module zbt_data_pipe #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              out_en_n,
  input  logic              s1_vld,
  input  logic              s1_wr,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [LANES-1:0]  s1_lane_n,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [ADDR_W-1:0] ram_wr_addr,
  output logic [LANES-1:0]  ram_wr_lane,
  output logic [DATA_W-1:0] ram_wr_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              s2_vld;
  logic              s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lane_n;
  logic              byp_hit_q;
  logic [DATA_W-1:0] byp_data_q;
  logic [LANES-1:0]  byp_lane_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld       <= 1'b0;
      s2_wr        <= 1'b0;
      s2_addr      <= '0;
      s2_lane_n    <= '1;
      byp_hit_q    <= 1'b0;
      byp_data_q   <= '0;
      byp_lane_n_q <= '1;
    end else if (!clk_en_n) begin
      s2_vld       <= s1_vld;
      s2_wr        <= s1_wr;
      s2_addr      <= s1_addr;
      s2_lane_n    <= s1_lane_n;
      // Read taken one edge after a write to the same word: the array
      // is read and written on this same edge, so keep the new lanes
      byp_hit_q    <= s1_vld && !s1_wr && s2_vld && s2_wr && (s1_addr == s2_addr);
      byp_data_q   <= dq_in;
      byp_lane_n_q <= s2_lane_n;
    end
  end

  assign ram_rd_en   = !clk_en_n;
  assign ram_wr_en   = !clk_en_n && s2_vld && s2_wr;
  assign ram_wr_addr = s2_addr;
  assign ram_wr_lane = ~s2_lane_n;
  assign ram_wr_data = dq_in;

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign dq_out[l*LANE_W +: LANE_W] = (byp_hit_q && !byp_lane_n_q[l]) ?
                                        byp_data_q[l*LANE_W +: LANE_W] :
                                        ram_rdata[l*LANE_W +: LANE_W];
  end

  assign dq_oe = s2_vld && !s2_wr && !out_en_n;

  AST_WR_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && s1_vld && s1_wr) |=> !dq_oe); // R5

  AST_IDLE_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !s1_vld) |=> !dq_oe); // R7

  AST_RD_PHASE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && s1_vld && !s1_wr) |=> (dq_oe == !out_en_n)); // R4

endmodule

// File: rtl/zbt_ram_core.sv
module zbt_ram_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  localparam int LANES = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-clock array with lane write enables
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lane[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9,
  parameter int WRAP_W = 2,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              cs_c,
  input  logic              adv_burst,
  input  logic              rd_not_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              acc_vld;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_lane_n;
  logic [DATA_W-1:0] ram_rdata;
  logic              ram_rd_en;
  logic              ram_wr_en;
  logic [ADDR_W-1:0] ram_wr_addr;
  logic [LANES-1:0]  ram_wr_lane;
  logic [DATA_W-1:0] ram_wr_data;

  zbt_cmd_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .WRAP_W (WRAP_W)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .cs_a_n     (cs_a_n),
    .cs_b_n     (cs_b_n),
    .cs_c       (cs_c),
    .adv_burst  (adv_burst),
    .rd_not_wr  (rd_not_wr),
    .addr       (addr),
    .lane_wr_n  (lane_wr_n),
    .acc_vld    (acc_vld),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .acc_lane_n (acc_lane_n)
  );

  zbt_data_pipe #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) pipe_i (
    .clk         (clk),
    .rst         (rst),
    .clk_en_n    (clk_en_n),
    .out_en_n    (out_en_n),
    .s1_vld      (acc_vld),
    .s1_wr       (acc_wr),
    .s1_addr     (acc_addr),
    .s1_lane_n   (acc_lane_n),
    .ram_rdata   (ram_rdata),
    .dq_in       (dq_in),
    .ram_rd_en   (ram_rd_en),
    .ram_wr_en   (ram_wr_en),
    .ram_wr_addr (ram_wr_addr),
    .ram_wr_lane (ram_wr_lane),
    .ram_wr_data (ram_wr_data),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe)
  );

  zbt_ram_core #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) ram_i (
    .clk     (clk),
    .rd_en   (ram_rd_en),
    .rd_addr (acc_addr),
    .rd_data (ram_rdata),
    .wr_en   (ram_wr_en),
    .wr_addr (ram_wr_addr),
    .wr_lane (ram_wr_lane),
    .wr_data (ram_wr_data)
  );

endmodule

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/100ps
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int LW = 9;
  localparam int NL = DW / LW;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    logic [NL-1:0] l;
    logic [DW-1:0] d;
  } ent_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_n = 1'b0, cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
  logic adv_burst = 1'b0, rd_not_wr = 1'b1, out_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_wr_n = '1;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #2 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .WRAP_W(2)) dut_i (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .cs_c(cs_c), .adv_burst(adv_burst), .rd_not_wr(rd_not_wr), .addr(addr),
    .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // Behavioural reference built from the requirements
  logic [DW-1:0] ref_mem [DEPTH];
  logic          m_active;
  logic          m_wr;
  logic [AW-1:0] m_addr;
  ent_t          p1, p2;
  int            n_chk = 0, n_bad = 0, seq = 0;
  string         cur_req = "R10";
  bit            finished = 0;

  function automatic logic [DW-1:0] gen(int s);
    return DW'(36'h1_2345_6789 + 36'(s) * 36'h0_9E37_79B9);
  endfunction

  task automatic check(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    p1 = '0; p2 = '0; m_active = 1'b0; m_wr = 1'b0; m_addr = '0;
  endtask

  // One clock: drive at the falling edge, check the current data phase,
  // then advance the reference at the rising edge
  task automatic cyc(bit cen, bit sa, bit sb, bit sc, bit adv, bit rd, int a,
                     logic [NL-1:0] ln, bit oe);
    ent_t nw;
    @(negedge clk);
    clk_en_n = cen; cs_a_n = sa; cs_b_n = sb; cs_c = sc;
    adv_burst = adv; rd_not_wr = rd; addr = AW'(a); lane_wr_n = ln; out_en_n = oe;
    dq_in = (p2.v && p2.w) ? p2.d : ~gen(seq + 1000);
    #1;
    if (p2.v && !p2.w) begin
      if (oe) check(!dq_oe, "read phase driven with output disabled", DW'(dq_oe), '0);
      else check(dq_oe && dq_out == ref_mem[p2.a], "read word", dq_oe ? dq_out : '1,
                 ref_mem[p2.a]);
    end else begin
      check(!dq_oe, "bus driven outside a read phase", DW'(dq_oe), '0);
    end
    @(posedge clk);
    if (!cen) begin
      if (p2.v && p2.w)
        for (int l = 0; l < NL; l++)
          if (!p2.l[l]) ref_mem[p2.a][l*LW +: LW] = p2.d[l*LW +: LW];
      p2 = p1;
      nw = '0;
      if (!adv) begin
        if (!sa && !sb && sc) begin
          m_active = 1'b1; m_addr = AW'(a); m_wr = !rd; nw.v = 1'b1;
        end else m_active = 1'b0;
      end else if (m_active) begin
        m_addr = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
        nw.v = 1'b1;
      end
      nw.w = m_wr; nw.a = m_addr; nw.l = ln; nw.d = gen(seq);
      seq++;
      p1 = nw;
    end
  endtask

  task automatic ld(bit rd, int a, logic [NL-1:0] ln, bit oe);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, rd, a, ln, oe);
  endtask
  task automatic bst(bit oe, int junk);
    cyc(1'b0, junk[0], junk[1], junk[2], 1'b1, junk[3], junk, NL'(0), oe);
  endtask
  task automatic stop(bit oe);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, '1, oe);
  endtask
  task automatic flush();
    stop(1'b0); stop(1'b0);
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; clk_en_n = 1'b0; adv_burst = 1'b0; cs_a_n = 1'b1;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10: bus quiet and bursts are no-ops right after reset
    cur_req = "R10";
    for (int i = 0; i < 4; i++) bst(1'b0, i);

    // R3 R8: back-to-back full writes then reads over every word
    cur_req = "R3 R8";
    for (int a = 0; a < DEPTH; a++) ld(1'b0, a, '0, 1'b0);
    for (int a = 0; a < DEPTH; a++) ld(1'b1, a, '0, 1'b0);
    flush();

    // R5: every lane mask
    cur_req = "R5";
    for (int a = 0; a < 16; a++) ld(1'b0, a, NL'(a), 1'b0);
    for (int a = 0; a < 16; a++) ld(1'b1, a, '0, 1'b0);
    flush();

    // R6: bursts from each start offset, five steps to show the wrap
    cur_req = "R6";
    for (int k = 0; k < 4; k++) begin
      ld(1'b0, 16 + 5*k, '0, 1'b0);
      for (int j = 0; j < 4; j++) bst(1'b0, 7*j + k);
    end
    flush();
    for (int k = 0; k < 4; k++) begin
      ld(1'b1, 16 + 5*k, '0, 1'b0);
      for (int j = 0; j < 4; j++) bst(1'b0, 3*j + k + 8);
    end
    flush();

    // R4: output enable gating on read phases
    cur_req = "R4";
    for (int a = 0; a < 8; a++) ld(1'b1, a, '0, a[0]);
    stop(1'b1); stop(1'b0);

    // R7: stop then no-ops; bus junk in their phases must not be stored
    cur_req = "R7";
    ld(1'b0, 40, '0, 1'b0);
    stop(1'b0);
    bst(1'b0, 5);
    bst(1'b0, 9);
    bst(1'b0, 2);
    ld(1'b1, 40, '0, 1'b0);
    ld(1'b1, 41, '0, 1'b0);
    stop(1'b0);
    bst(1'b0, 4);
    bst(1'b0, 6);

    // R1: every select combination on a write load
    cur_req = "R1";
    for (int c = 0; c < 8; c++)
      cyc(1'b0, c[2], c[1], c[0], 1'b0, 1'b0, 48 + c, '0, 1'b0);
    flush();
    for (int c = 0; c < 8; c++) ld(1'b1, 48 + c, '0, 1'b0);
    flush();

    // R2: freezes over a read phase, a write phase and an open burst
    cur_req = "R2";
    ld(1'b1, 3, '0, 1'b0);
    ld(1'b1, 4, '0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, i[0], 1'b0, 60 + i, '0, 1'b0);
    ld(1'b0, 33, 4'b1010, 1'b0);
    bst(1'b0, 1);
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9, '1, 1'b0);
    bst(1'b0, 2);
    flush();
    ld(1'b1, 33, '0, 1'b0);
    bst(1'b0, 0);
    bst(1'b0, 3);
    flush();

    // R9: read right after a write to the same word, varied lane masks
    cur_req = "R9";
    for (int i = 0; i < 8; i++) begin
      ld(1'b0, 8 + i, NL'(i * 3 + 1), 1'b0);
      ld(1'b1, 8 + i, '0, 1'b0);
    end
    flush();

    // R8: alternating write/read to different words, no idle cycles
    cur_req = "R8";
    for (int i = 0; i < 32; i++) ld(i[0], 24 + (i >> 1) + 4*i[0], NL'(i), 1'b0);
    flush();

    // R10: reset in the middle of pending accesses
    cur_req = "R10";
    ld(1'b1, 5, '0, 1'b0);
    ld(1'b1, 6, '0, 1'b0);
    do_reset();
    bst(1'b0, 1);
    bst(1'b0, 2);
    bst(1'b0, 3);
    ld(1'b1, 6, '0, 1'b0);
    flush();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule